// File: doc/BRIEF.md
# Flash Security and Access Gate

This block decides whether a small microcontroller's memories are locked, and it screens every bus access that arrives from the core, the debug port or the SPI slave port against that lock state. At reset it takes a two-bit lock code from a nonvolatile byte. Only one pattern of that code opens the part. The code can be moved to the open pattern in two ways: a correct eight-byte backdoor key written into a small address window, or a pulse from the flash blank-check engine reporting an empty array.

A configuration register holds a single key-enable bit. That bit decides whether writes into the key window are captured as key bytes or passed on to the flash engine as the start of a program or erase command. A protection byte is copied from nonvolatile storage at reset and can be rewritten afterwards only through the debug path. Accesses that the lock state forbids are answered with zero data and an error flag, and no strobe reaches the memory.

Top module: `flash_sec_gate`

## Requirements
- R1: Synchronous reset loads the lock code from `nv_sec_byte`. The value 8'hFF yields code 2'b11. Any other value yields its bits 1:0. The same reset clears the configuration register to 8'h00 and loads the protection byte with `nv_prot_byte` masked by 8'hF8.
- R2: `secured` is low only while `sec_code` equals 2'b10. The codes 2'b00, 2'b01 and 2'b11 all keep it high.
- R3: While secured, an SPI access (`acc_src`=2'b10) is served only at addresses 16'h0000–16'h008F and 16'h1800–16'h188F. Any other SPI access produces, one cycle later, `rsp_err`=1 for one cycle and `rsp_rdata`=8'h00, and it never raises `mem_we` or `mem_re`.
- R4: While secured, a debug access (`acc_src`=2'b01) to RAM (16'h0090–16'h048F) or flash (16'hC000–16'hFFFF) is denied in the same way. Debug accesses elsewhere are served.
- R5: Core accesses (`acc_src`=2'b00) are always served. While open, every source is served and `rsp_err` stays low.
- R6: The configuration register at 16'h1823 holds only bit 5, the key enable. Its other bits read as 0, and writes to them have no effect.
- R7: With the key enable at 0, an allowed write to 16'hFFB0–16'hFFB7 pulses `flash_cmd` and is forwarded on `mem_we` in the same cycle.
- R8: With the key enable at 1, such writes are captured as key bytes and raise neither `flash_cmd` nor `mem_we`. Byte i belongs at 16'hFFB0+i and is compared with `nv_key[63-8i -: 8]`. When all eight bytes have arrived in address order and match, the code becomes 2'b10 at the edge that takes the eighth byte.
- R9: A full eight-byte entry that does not match leaves the code unchanged. A byte written out of address order discards the bytes entered so far (a stray byte at offset 0 restarts the entry).
- R10: A `blank_ok` pulse sets the code to 2'b10.
- R11: The protection byte at 16'h1824 can be read by any served source. Only debug writes change it, and its bits 2:0 stay 0. Core and SPI writes to it are ignored without error.
- R12: An access is judged against the lock code held before the clock edge that takes it. An unlock in the same cycle affects only later accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nv_sec_byte | input | 8 | Nonvolatile security byte sampled during reset |
| nv_prot_byte | input | 8 | Nonvolatile protection byte sampled during reset |
| nv_key | input | 64 | Stored backdoor key; byte 0 is bits 63:56 |
| blank_ok | input | 1 | Pulse: blank check of flash succeeded |
| acc_valid | input | 1 | Access request this cycle |
| acc_src | input | 2 | Source: 00 core, 01 debug, 10 SPI |
| acc_write | input | 1 | 1 write, 0 read |
| acc_addr | input | 16 | Access address |
| acc_wdata | input | 8 | Write data |
| mem_rdata | input | 8 | Read data returned by memory for a forwarded read |
| mem_we | output | 1 | Forwarded write strobe |
| mem_re | output | 1 | Forwarded read strobe |
| flash_cmd | output | 1 | Pulse: start a flash program/erase command |
| rsp_valid | output | 1 | Response for the previous cycle's access |
| rsp_rdata | output | 8 | Response read data |
| rsp_err | output | 1 | Access denied |
| sec_code | output | 2 | Current lock code |
| secured | output | 1 | Memories locked |

## Verification
An unlock event and a screened access can land on the same clock edge. The risk is that the gate uses the new code too early, or drops the unlock. The bench raises `blank_ok` in the same cycle as an SPI read outside the permitted windows. That read must still come back with an error, the code must read 2'b10 straight afterwards, and a repeat of the same read must then succeed with the memory's data. The eighth key byte is a second same-cycle case: it both unlocks the part and is itself a write that must not reach memory.

// File: rtl/flash_sec_pkg.sv
// Package: shared source encoding, lock codes and address helpers for the
// flash security gate. Assumes 16-bit addresses and byte-wide data.
package flash_sec_pkg;

    typedef enum logic [1:0] {
        SRC_CPU  = 2'b00,
        SRC_DBG  = 2'b01,
        SRC_SPI  = 2'b10,
        SRC_RSVD = 2'b11
    } src_e;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;

    localparam logic [1:0] SEC_OPEN   = 2'b10;
    localparam logic [1:0] SEC_ERASED = 2'b11;

    // Inclusive address range test.
    function automatic logic in_span(input logic [ADDR_W-1:0] a,
                                     input logic [ADDR_W-1:0] lo,
                                     input logic [ADDR_W-1:0] hi);
        return (a >= lo) && (a <= hi);
    endfunction

endpackage

// File: rtl/fsg_filter.sv
// Access filter: purely combinational permission decision for one access.
// Core accesses are always served; when secured, SPI is confined to the
// listed windows and debug is kept off RAM and flash. Assumes the window
// lists hold N_WIN inclusive ranges.
module fsg_filter
    import flash_sec_pkg::*;
#(
    parameter int                           N_WIN    = 2,
    parameter logic [N_WIN-1:0][ADDR_W-1:0] WIN_LO   = {16'h1800, 16'h0000},
    parameter logic [N_WIN-1:0][ADDR_W-1:0] WIN_HI   = {16'h188F, 16'h008F},
    parameter logic [ADDR_W-1:0]            RAM_LO   = 16'h0090,
    parameter logic [ADDR_W-1:0]            RAM_HI   = 16'h048F,
    parameter logic [ADDR_W-1:0]            FLASH_LO = 16'hC000,
    parameter logic [ADDR_W-1:0]            FLASH_HI = 16'hFFFF
) (
    input  logic [1:0]        src,
    input  logic [ADDR_W-1:0] addr,
    input  logic              secured,
    output logic              allow
);

    logic [N_WIN-1:0] win_hit;
    logic             any_win;
    logic             mem_area;

    // One comparator pair per permitted SPI window.
    for (genvar w = 0; w < N_WIN; w++) begin : g_win
        assign win_hit[w] = in_span(addr, WIN_LO[w], WIN_HI[w]);
    end

    assign any_win  = |win_hit;
    assign mem_area = in_span(addr, RAM_LO, RAM_HI) || in_span(addr, FLASH_LO, FLASH_HI);

    // Permission decision by source and lock state.
    always_comb begin
        allow = 1'b1;
        if (secured) begin
            case (src_e'(src))
                SRC_CPU: allow = 1'b1;
                SRC_DBG: allow = !mem_area;
                default: allow = any_win;
            endcase
        end
    end

endmodule

// File: rtl/fsg_sec_state.sv
// Lock state: holds the two-bit lock code, collects backdoor key bytes in
// address order and compares them once the last byte arrives. Assumes
// key_we is already qualified (allowed access, key enable set, in window).
module fsg_sec_state
    import flash_sec_pkg::*;
#(
    parameter int KEY_BYTES = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [DATA_W-1:0]          nv_sec_byte,
    input  logic [KEY_BYTES*8-1:0]     nv_key,
    input  logic                       key_we,
    input  logic [$clog2(KEY_BYTES)-1:0] key_off,
    input  logic [DATA_W-1:0]          key_byte,
    input  logic                       blank_ok,
    output logic [1:0]                 sec_code
);

    localparam int                 KEY_W    = KEY_BYTES * 8;
    localparam int                 IDX_W    = $clog2(KEY_BYTES);
    localparam logic [IDX_W-1:0]   LAST_IDX = IDX_W'(KEY_BYTES - 1);

    logic [IDX_W-1:0] idx_q;
    logic [KEY_W-1:0] buf_q;
    logic [KEY_W-1:0] buf_nx;
    logic             in_order;
    logic             complete;
    logic             key_match;

    // Place the incoming byte into a copy of the collected key.
    always_comb begin
        buf_nx = buf_q;
        for (int i = 0; i < KEY_BYTES; i++) begin
            if (key_off == IDX_W'(i)) begin
                buf_nx[(KEY_BYTES-1-i)*8 +: 8] = key_byte;
            end
        end
    end

    assign in_order  = (key_off == idx_q);
    assign complete  = in_order && (idx_q == LAST_IDX);
    assign key_match = complete && (buf_nx == nv_key);

    // Lock code: reset load from nonvolatile byte, opened by key or blank check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_code <= (nv_sec_byte == 8'hFF) ? SEC_ERASED : nv_sec_byte[1:0];
        end else if (blank_ok || (key_we && key_match)) begin
            sec_code <= SEC_OPEN;
        end
    end

    // Key collection: advance on in-order bytes, clear on completion or disorder.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            buf_q <= '0;
        end else if (key_we) begin
            if (complete) begin
                idx_q <= '0;
                buf_q <= '0;
            end else if (in_order) begin
                idx_q <= idx_q + 1'b1;
                buf_q <= buf_nx;
            end else if (key_off == '0) begin
                idx_q <= IDX_W'(1);
                buf_q <= {key_byte, {(KEY_W-8){1'b0}}};
            end else begin
                idx_q <= '0;
                buf_q <= '0;
            end
        end
    end

endmodule

// File: rtl/fsg_regs.sv
// Control registers: the configuration byte (one writable key-enable bit)
// and the protection byte. Assumes write enables are already qualified by
// address, permission and, for protection, by debug source.
module fsg_regs
    import flash_sec_pkg::*;
#(
    parameter int                KEYACC_BIT = 5,
    parameter logic [DATA_W-1:0] PROT_MASK  = 8'hF8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              prot_we,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] nv_prot_byte,
    output logic              keyacc,
    output logic [DATA_W-1:0] cfg_rd,
    output logic [DATA_W-1:0] prot_q
);

    // Key-enable bit: cleared by reset, written from its bit position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            keyacc <= 1'b0;
        end else if (cfg_we) begin
            keyacc <= wdata[KEYACC_BIT];
        end
    end

    // Protection byte: copied at reset, rewritten only by qualified writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prot_q <= nv_prot_byte & PROT_MASK;
        end else if (prot_we) begin
            prot_q <= wdata & PROT_MASK;
        end
    end

    // Read view of the configuration byte: unused bits read as zero.
    always_comb begin
        cfg_rd             = '0;
        cfg_rd[KEYACC_BIT] = keyacc;
    end

endmodule

// File: rtl/flash_sec_gate.sv
// Top: decodes register and key-window addresses, applies the filter,
// steers strobes to memory, key logic or flash engine, and registers a
// one-cycle-late response. Assumes mem_rdata is valid in the request cycle.
module flash_sec_gate
    import flash_sec_pkg::*;
#(
    parameter int                KEY_BYTES = 8,
    parameter logic [ADDR_W-1:0] KEY_BASE  = 16'hFFB0,
    parameter logic [ADDR_W-1:0] CFG_ADDR  = 16'h1823,
    parameter logic [ADDR_W-1:0] PROT_ADDR = 16'h1824
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [7:0]             nv_sec_byte,
    input  logic [7:0]             nv_prot_byte,
    input  logic [KEY_BYTES*8-1:0] nv_key,
    input  logic                   blank_ok,
    input  logic                   acc_valid,
    input  logic [1:0]             acc_src,
    input  logic                   acc_write,
    input  logic [15:0]            acc_addr,
    input  logic [7:0]             acc_wdata,
    input  logic [7:0]             mem_rdata,
    output logic                   mem_we,
    output logic                   mem_re,
    output logic                   flash_cmd,
    output logic                   rsp_valid,
    output logic [7:0]             rsp_rdata,
    output logic                   rsp_err,
    output logic [1:0]             sec_code,
    output logic                   secured
);

    localparam int                IDX_W    = $clog2(KEY_BYTES);
    localparam logic [ADDR_W-1:0] KEY_LAST = KEY_BASE + ADDR_W'(KEY_BYTES - 1);

    logic              allow;
    logic              acc_ok;
    logic              wr_ok;
    logic              is_cfg;
    logic              is_prot;
    logic              in_key;
    logic [ADDR_W-1:0] key_rel;
    logic              key_we;
    logic              cfg_we;
    logic              prot_we;
    logic              keyacc;
    logic [7:0]        cfg_rd;
    logic [7:0]        prot_q;
    logic [7:0]        rd_sel;

    assign secured = (sec_code != SEC_OPEN);

    fsg_filter u_filter (
        .src     (acc_src),
        .addr    (acc_addr),
        .secured (secured),
        .allow   (allow)
    );

    // Address decode of the local registers and the key window.
    always_comb begin
        is_cfg  = (acc_addr == CFG_ADDR);
        is_prot = (acc_addr == PROT_ADDR);
        in_key  = in_span(acc_addr, KEY_BASE, KEY_LAST);
        key_rel = acc_addr - KEY_BASE;
    end

    // Strobe steering for a served access.
    always_comb begin
        acc_ok    = acc_valid && allow;
        wr_ok     = acc_ok && acc_write;
        key_we    = wr_ok && in_key && keyacc;
        flash_cmd = wr_ok && in_key && !keyacc;
        cfg_we    = wr_ok && is_cfg;
        prot_we   = wr_ok && is_prot && (acc_src == SRC_DBG);
        mem_we    = wr_ok && !is_cfg && !is_prot && !key_we;
        mem_re    = acc_ok && !acc_write && !is_cfg && !is_prot;
    end

    fsg_sec_state #(.KEY_BYTES(KEY_BYTES)) u_state (
        .clk         (clk),
        .rst_n       (rst_n),
        .nv_sec_byte (nv_sec_byte),
        .nv_key      (nv_key),
        .key_we      (key_we),
        .key_off     (key_rel[IDX_W-1:0]),
        .key_byte    (acc_wdata),
        .blank_ok    (blank_ok),
        .sec_code    (sec_code)
    );

    fsg_regs u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we       (cfg_we),
        .prot_we      (prot_we),
        .wdata        (acc_wdata),
        .nv_prot_byte (nv_prot_byte),
        .keyacc       (keyacc),
        .cfg_rd       (cfg_rd),
        .prot_q       (prot_q)
    );

    // Read data source for a served read.
    always_comb begin
        if (is_cfg)       rd_sel = cfg_rd;
        else if (is_prot) rd_sel = prot_q;
        else              rd_sel = mem_rdata;
    end

    // Response register: one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= acc_valid;
            rsp_err   <= acc_valid && !allow;
            rsp_rdata <= (acc_ok && !acc_write) ? rd_sel : '0;
        end
    end

endmodule

// File: rtl/flash_sec_gate_chk.sv
// Checker: temporal properties of the security gate, bound to the top.
// Assumes the default window and register addresses of the top.
module flash_sec_gate_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        acc_valid,
    input logic [1:0]  acc_src,
    input logic        acc_write,
    input logic [15:0] acc_addr,
    input logic        blank_ok,
    input logic        mem_we,
    input logic        mem_re,
    input logic        rsp_err,
    input logic [7:0]  rsp_rdata,
    input logic [1:0]  sec_code,
    input logic        secured,
    input logic [7:0]  prot_q
);

    logic started;
    logic spi_ok;
    logic dbg_mem;
    logic key_hit;

    // Marks that at least one cycle has passed since reset released.
    always_ff @(posedge clk) begin
        if (!rst_n) started <= 1'b0;
        else        started <= 1'b1;
    end

    assign spi_ok  = (acc_addr <= 16'h008F) || (acc_addr >= 16'h1800 && acc_addr <= 16'h188F);
    assign dbg_mem = (acc_addr >= 16'h0090 && acc_addr <= 16'h048F) || (acc_addr >= 16'hC000);
    assign key_hit = acc_valid && acc_write && acc_addr >= 16'hFFB0 && acc_addr <= 16'hFFB7;

    AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_rdata == 8'h00)); // R3
    AST_ERR_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n || !started)
        rsp_err |-> $past(acc_valid)); // R3
    AST_SPI_CONFINED: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_src == 2'b10 && secured && !spi_ok) |-> (!mem_we && !mem_re)); // R3
    AST_DBG_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_src == 2'b01 && secured && dbg_mem) |-> (!mem_we && !mem_re)); // R4
    AST_ERR_ONLY_LOCKED: assert property (@(posedge clk) disable iff (!rst_n || !started)
        rsp_err |-> $past(secured)); // R5
    AST_UNLOCK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n || !started)
        (sec_code == 2'b10 && $past(sec_code) != 2'b10) |-> $past(blank_ok || key_hit)); // R8
    AST_PROT_DBG_ONLY: assert property (@(posedge clk) disable iff (!rst_n || !started)
        !$stable(prot_q) |-> $past(acc_valid && acc_write && acc_src == 2'b01 && acc_addr == 16'h1824)); // R11

endmodule

bind flash_sec_gate flash_sec_gate_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_src   (acc_src),
    .acc_write (acc_write),
    .acc_addr  (acc_addr),
    .blank_ok  (blank_ok),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .rsp_err   (rsp_err),
    .rsp_rdata (rsp_rdata),
    .sec_code  (sec_code),
    .secured   (secured),
    .prot_q    (prot_q)
);

// File: tb/flash_sec_gate_bench.sv
`timescale 1ns/100ps
module flash_sec_gate_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  nv_sec_byte = 8'hFF;
    logic [7:0]  nv_prot_byte = 8'hB7;
    logic [63:0] nv_key = 64'h0123456789ABCDEF;
    logic        blank_ok = 1'b0;
    logic        acc_valid = 1'b0;
    logic [1:0]  acc_src = 2'b00;
    logic        acc_write = 1'b0;
    logic [15:0] acc_addr = '0;
    logic [7:0]  acc_wdata = '0;
    logic [7:0]  mem_rdata;
    logic        mem_we, mem_re, flash_cmd, rsp_valid, rsp_err, secured;
    logic [7:0]  rsp_rdata;
    logic [1:0]  sec_code;

    int checks = 0;
    int fails  = 0;
    logic g_err, g_mwe, g_cmd;
    logic [7:0] g_rd;

    always #2.5 clk = ~clk;

    // Memory model: data depends only on the low address byte.
    assign mem_rdata = acc_addr[7:0] ^ 8'h5A;

    flash_sec_gate u_flash_sec_gate (
        .clk(clk), .rst_n(rst_n), .nv_sec_byte(nv_sec_byte), .nv_prot_byte(nv_prot_byte),
        .nv_key(nv_key), .blank_ok(blank_ok), .acc_valid(acc_valid), .acc_src(acc_src),
        .acc_write(acc_write), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .mem_rdata(mem_rdata), .mem_we(mem_we), .mem_re(mem_re), .flash_cmd(flash_cmd),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .sec_code(sec_code), .secured(secured)
    );

    // Vector: {src[1:0], write, addr[15:0], wdata[7:0], exp_err, exp_rdata[7:0], exp_mem_we}
    localparam int NVEC = 16;
    localparam logic [36:0] VECS [NVEC] = '{
        {2'b10, 1'b0, 16'h0000, 8'h00, 1'b0, 8'h5A, 1'b0},
        {2'b10, 1'b0, 16'h008F, 8'h00, 1'b0, 8'hD5, 1'b0},
        {2'b10, 1'b0, 16'h0090, 8'h00, 1'b1, 8'h00, 1'b0},
        {2'b10, 1'b0, 16'h17FF, 8'h00, 1'b1, 8'h00, 1'b0},
        {2'b10, 1'b0, 16'h1800, 8'h00, 1'b0, 8'h5A, 1'b0},
        {2'b10, 1'b0, 16'h188F, 8'h00, 1'b0, 8'hD5, 1'b0},
        {2'b10, 1'b0, 16'h1890, 8'h00, 1'b1, 8'h00, 1'b0},
        {2'b10, 1'b1, 16'h0040, 8'h11, 1'b0, 8'h00, 1'b1},
        {2'b10, 1'b1, 16'hFFB0, 8'h01, 1'b1, 8'h00, 1'b0},
        {2'b01, 1'b0, 16'h0100, 8'h00, 1'b1, 8'h00, 1'b0},
        {2'b01, 1'b0, 16'hC000, 8'h00, 1'b1, 8'h00, 1'b0},
        {2'b01, 1'b0, 16'h1000, 8'h00, 1'b0, 8'h5A, 1'b0},
        {2'b00, 1'b0, 16'hC000, 8'h00, 1'b0, 8'h5A, 1'b0},
        {2'b00, 1'b1, 16'h0100, 8'h22, 1'b0, 8'h00, 1'b1},
        {2'b10, 1'b0, 16'h1823, 8'h00, 1'b0, 8'h00, 1'b0},
        {2'b10, 1'b0, 16'h1824, 8'h00, 1'b0, 8'hB0, 1'b0}
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One access: strobes sampled in the request cycle, response one cycle later.
    task automatic access(input logic [1:0] s, input logic w, input logic [15:0] a,
                          input logic [7:0] d, input logic bl);
        @(negedge clk);
        acc_valid = 1'b1; acc_src = s; acc_write = w; acc_addr = a; acc_wdata = d; blank_ok = bl;
        #1;
        g_mwe = mem_we; g_cmd = flash_cmd;
        @(negedge clk);
        g_err = rsp_err; g_rd = rsp_rdata;
        acc_valid = 1'b0; blank_ok = 1'b0;
    endtask

    task automatic do_reset(input logic [7:0] sb, input logic [7:0] pb);
        @(negedge clk);
        rst_n = 1'b0; nv_sec_byte = sb; nv_prot_byte = pb;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic key_byte(input int i, input logic [7:0] d);
        access(2'b00, 1'b1, 16'hFFB0 + 16'(i), d, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        // R1: erased security byte comes up secured with code 11
        do_reset(8'hFF, 8'hB7);
        #1;
        chk("R1 erased code", sec_code, 2'b11);
        chk("R2 secured high", secured, 1'b1);
        chk("R1 no error out of reset", rsp_err, 1'b0);

        // Vector table under the secured state (R3 R4 R5 R1 R6 R11)
        for (int v = 0; v < NVEC; v++) begin
            access(VECS[v][36:35], VECS[v][34], VECS[v][33:18], VECS[v][17:10], 1'b0);
            chk($sformatf("R3/R4/R5 vec%0d err", v), g_err, VECS[v][9]);
            chk($sformatf("R3/R4/R5 vec%0d rdata", v), g_rd, VECS[v][8:1]);
            chk($sformatf("R3/R4/R5 vec%0d mem_we", v), g_mwe, VECS[v][0]);
        end

        // R6: only bit 5 of the configuration byte holds
        access(2'b00, 1'b1, 16'h1823, 8'hFF, 1'b0);
        access(2'b00, 1'b0, 16'h1823, 8'h00, 1'b0);
        chk("R6 cfg readback", g_rd, 8'h20);

        // R11: core and SPI writes ignored, debug writes land with low bits zero
        access(2'b00, 1'b1, 16'h1824, 8'hFF, 1'b0);
        chk("R11 core write no error", g_err, 1'b0);
        access(2'b10, 1'b1, 16'h1824, 8'h00, 1'b0);
        access(2'b00, 1'b0, 16'h1824, 8'h00, 1'b0);
        chk("R11 prot unchanged", g_rd, 8'hB0);
        access(2'b01, 1'b1, 16'h1824, 8'h5F, 1'b0);
        access(2'b10, 1'b0, 16'h1824, 8'h00, 1'b0);
        chk("R11 debug write", g_rd, 8'h58);

        // R9: full mismatching key leaves the lock
        for (int i = 0; i < 8; i++) key_byte(i, (i == 3) ? 8'h00 : nv_key[63-8*i -: 8]);
        chk("R9 mismatch keeps code", sec_code, 2'b11);
        // R9: out-of-order byte discards the partial entry
        for (int i = 0; i < 4; i++) key_byte(i, nv_key[63-8*i -: 8]);
        key_byte(5, nv_key[63-40 -: 8]);
        for (int i = 4; i < 8; i++) key_byte(i, nv_key[63-8*i -: 8]);
        chk("R9 disorder clears entry", sec_code, 2'b11);
        // R8: correct key unlocks; key writes reach neither memory nor flash engine
        for (int i = 0; i < 7; i++) key_byte(i, nv_key[63-8*i -: 8]);
        chk("R8 partial still locked", sec_code, 2'b11);
        key_byte(7, 8'hEF);
        chk("R8 key no mem_we", g_mwe, 1'b0);
        chk("R8 key no flash_cmd", g_cmd, 1'b0);
        chk("R8 unlocked", sec_code, 2'b10);
        chk("R2 secured low", secured, 1'b0);
        // R5: open part serves SPI anywhere
        access(2'b10, 1'b0, 16'hC000, 8'h00, 1'b0);
        chk("R5 open spi err", g_err, 1'b0);
        chk("R5 open spi data", g_rd, 8'h5A);

        // R12 R10: blank check in the same cycle as a denied access
        do_reset(8'hFF, 8'hB7);
        access(2'b10, 1'b0, 16'h0090, 8'h00, 1'b1);
        chk("R12 same-cycle access denied", g_err, 1'b1);
        chk("R10 blank check unlocks", sec_code, 2'b10);
        access(2'b10, 1'b0, 16'h0090, 8'h00, 1'b0);
        chk("R12 next access served", g_err, 1'b0);
        chk("R12 next access data", g_rd, 8'hCA);

        // R1 R2: other reset codes
        do_reset(8'h00, 8'h07);
        #1;
        chk("R1 code 00", sec_code, 2'b00);
        chk("R2 code 00 secured", secured, 1'b1);
        access(2'b00, 1'b0, 16'h1824, 8'h00, 1'b0);
        chk("R1 prot masked", g_rd, 8'h00);
        do_reset(8'h02, 8'hB7);
        #1;
        chk("R1 code 10", sec_code, 2'b10);
        chk("R2 code 10 open", secured, 1'b0);

        // R7: key enable clear sends key-window writes to the flash engine
        access(2'b00, 1'b1, 16'hFFB3, 8'h44, 1'b0);
        chk("R7 flash_cmd", g_cmd, 1'b1);
        chk("R7 mem_we", g_mwe, 1'b1);
        access(2'b00, 1'b1, 16'h0200, 8'h44, 1'b0);
        chk("R7 no cmd outside window", g_cmd, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule